// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block sits between a CAN frame decoder and the receive FIFO and decides whether a frame should be kept. It holds a small bank of filters. Each filter has a mask word, a match word and an enable bit. Every incoming 32-bit identifier word is compared against all enabled filters in the same cycle. The frame is kept when at least one enabled filter matches. When no filter is enabled, every frame is kept. The decision comes out registered, one clock after the identifier strobe, together with a per-filter hit vector.

A configuration port writes the mask words, the match words and the enable vector. A busy flag tells the configuring agent when the bank cannot take writes: it is high in the cycle after a comparison starts and in the cycle after the enable vector changes. Any write made while busy is dropped. A mask or match write aimed at a filter that is enabled is also dropped, so a filter's contents can only change while it is out of service.

The identifier word uses this layout: bits 31:21 hold the standard identifier, bit 20 the substitute remote request, bit 19 the extension flag, bits 18:1 the extended identifier and bit 0 the remote request flag. The block does not decode these fields. Masking applies bit by bit across the whole word, so any mix of fields can be selected.

Top module: `can_accept_bank`

## Requirements
- R1: After reset, dec_valid, dec_accept, dec_hit and busy are all 0, every filter is disabled, and every mask and match word is 0.
- R2: Filter i hits when it is enabled and ((id_word XOR match_i) AND mask_i) is zero. dec_hit[i] reports this for the identifier sampled with the strobe.
- R3: When at least one filter is enabled, dec_accept is the OR of all the dec_hit bits.
- R4: When no filter is enabled at the strobe, dec_accept is 1 and dec_hit is all zeros.
- R5: dec_valid is high for exactly the cycle after each cycle in which id_valid is high. dec_accept and dec_hit belong to the identifier sampled in that strobe cycle.
- R6: busy is high in the cycle after any cycle in which id_valid is high.
- R7: A write with cfg_sel = 2 loads cfg_wdata[NUM_FILT-1:0] into the enable vector (bit i enables filter i). If the value changes, busy is high for the next cycle. Rewriting the same value does not raise busy.
- R8: A write with cfg_sel = 0 (mask) or cfg_sel = 1 (match) loads cfg_wdata into filter cfg_idx only if that filter is disabled. Otherwise the write has no effect. cfg_sel = 3 writes nothing.
- R9: Every configuration write made while busy is high is ignored, including enable writes.
- R10: A mask bit of 0 makes the matching identifier bit a don't-care. For example, a mask of 0xFFE00000 selects only the standard identifier field, and any value of the lower fields still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 mask, 1 match, 2 enable vector, 3 none |
| cfg_idx | input | IDX_W | Filter index for mask and match writes |
| cfg_wdata | input | ID_W | Write data |
| id_valid | input | 1 | Identifier present strobe |
| id_word | input | ID_W | Received identifier word |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = store frame, 0 = drop frame |
| dec_hit | output | NUM_FILT | Per-filter hit vector |
| busy | output | 1 | Configuration writes are dropped while high |

## Verification
A corrupted mask or match word shows up as a wrong dec_hit bit. It appears on the very next identifier that exercises the affected bits, one cycle after that identifier's strobe. A lost or stuck enable bit shows up in two ways: wrong hits, and a wrong accept-everything fallback once all filters look disabled. A broken write interlock does not show up as a flag. It shows up later, as hits from contents that should never have been loaded. For that reason, each ignored write is followed by identifiers chosen to expose the old and new contents. A busy flag that is wrong is seen within one cycle, because an enable write that the bench expects to be dropped would take effect instead.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;

    typedef enum logic [1:0] {
        OP_MASK = 2'd0,
        OP_ID   = 2'd1,
        OP_EN   = 2'd2,
        OP_NONE = 2'd3
    } cfg_op_e;

endpackage

// File: rtl/can_acf_match.sv
module can_acf_match #(
    parameter int ID_W = 32
) (
    input  logic            en,
    input  logic [ID_W-1:0] mask,
    input  logic [ID_W-1:0] fid,
    input  logic [ID_W-1:0] id_word,
    output logic            hit
);
    logic [ID_W-1:0] diff;

    always_comb begin
        diff = (id_word ^ fid) & mask;
        hit  = en && (diff == '0);
    end
endmodule

// File: rtl/can_acf_cfg.sv
module can_acf_cfg
    import can_acf_pkg::*;
#(
    parameter int NUM_FILT = 4,
    parameter int ID_W     = 32,
    parameter int IDX_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  cfg_op_e                        op,
    input  logic [IDX_W-1:0]               idx,
    input  logic [ID_W-1:0]                wdata,
    input  logic                           id_valid,
    output logic [NUM_FILT-1:0][ID_W-1:0]  mask_o,
    output logic [NUM_FILT-1:0][ID_W-1:0]  fid_o,
    output logic [NUM_FILT-1:0]            en_o,
    output logic                           busy_o
);
    typedef struct packed {
        logic [NUM_FILT-1:0][ID_W-1:0] mask;
        logic [NUM_FILT-1:0][ID_W-1:0] fid;
        logic [NUM_FILT-1:0]           en;
        logic                          busy;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    idx_ok;

    always_comb begin
        st_d      = st_q;
        st_d.busy = id_valid;
        idx_ok    = (32'(idx) < NUM_FILT);
        if (wr_en && !st_q.busy) begin
            case (op)
                OP_MASK: if (idx_ok && !st_q.en[idx]) st_d.mask[idx] = wdata;
                OP_ID:   if (idx_ok && !st_q.en[idx]) st_d.fid[idx]  = wdata;
                OP_EN: begin
                    st_d.en = wdata[NUM_FILT-1:0];
                    if (wdata[NUM_FILT-1:0] != st_q.en) st_d.busy = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign fid_o  = st_q.fid;
    assign en_o   = st_q.en;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/can_accept_bank.sv
module can_accept_bank
    import can_acf_pkg::*;
#(
    parameter int NUM_FILT = 4,
    parameter int ID_W     = 32,
    localparam int IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [1:0]          cfg_sel,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ID_W-1:0]     cfg_wdata,
    input  logic                id_valid,
    input  logic [ID_W-1:0]     id_word,
    output logic                dec_valid,
    output logic                dec_accept,
    output logic [NUM_FILT-1:0] dec_hit,
    output logic                busy
);
    logic [NUM_FILT-1:0][ID_W-1:0] mask_w;
    logic [NUM_FILT-1:0][ID_W-1:0] fid_w;
    logic [NUM_FILT-1:0]           en_w;
    logic [NUM_FILT-1:0]           hit_w;

    can_acf_cfg #(.NUM_FILT(NUM_FILT), .ID_W(ID_W), .IDX_W(IDX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .op       (cfg_op_e'(cfg_sel)),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .id_valid (id_valid),
        .mask_o   (mask_w),
        .fid_o    (fid_w),
        .en_o     (en_w),
        .busy_o   (busy)
    );

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        can_acf_match #(.ID_W(ID_W)) u_match (
            .en      (en_w[g]),
            .mask    (mask_w[g]),
            .fid     (fid_w[g]),
            .id_word (id_word),
            .hit     (hit_w[g])
        );
    end

    typedef struct packed {
        logic                valid;
        logic                accept;
        logic [NUM_FILT-1:0] hit;
    } dec_st_t;

    dec_st_t dec_d, dec_q;

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = id_valid;
        if (id_valid) begin
            dec_d.hit    = hit_w;
            dec_d.accept = (en_w == '0) ? 1'b1 : (|hit_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_hit    = dec_q.hit;
endmodule

// File: rtl/can_acf_chk.sv
module can_acf_chk #(
    parameter int NUM_FILT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                id_valid,
    input logic                cfg_wr_en,
    input logic                dec_valid,
    input logic                dec_accept,
    input logic [NUM_FILT-1:0] dec_hit,
    input logic                busy,
    input logic [NUM_FILT-1:0] en
);
    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> dec_valid); // R5
    AST_DEC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> !dec_valid); // R5
    AST_BUSY_AFTER_ID: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> busy); // R6
    AST_BUSY_ON_EN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en != $past(en)) |-> busy); // R7
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr_en) |=> $stable(en)); // R9
    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && en == '0) |=> (dec_accept && dec_hit == '0)); // R4
    AST_HIT_IMPLIES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_hit != '0) |-> dec_accept); // R3
endmodule

bind can_accept_bank can_acf_chk #(.NUM_FILT(NUM_FILT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_valid   (id_valid),
    .cfg_wr_en  (cfg_wr_en),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_hit    (dec_hit),
    .busy       (busy),
    .en         (en_w)
);

// File: tb/test_can_accept_bank.sv
module test_can_accept_bank;
    localparam int NF = 4;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_sel = 2'd3;
    logic [1:0]    cfg_idx = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          id_valid = 1'b0;
    logic [W-1:0]  id_word = '0;
    logic          dec_valid, dec_accept, busy;
    logic [NF-1:0] dec_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0]  m_mask [NF];
    logic [W-1:0]  m_fid  [NF];
    logic [NF-1:0] m_en;

    always #5 clk = ~clk;

    can_accept_bank #(.NUM_FILT(NF), .ID_W(W)) i_can_accept_bank (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .id_valid(id_valid),
        .id_word(id_word), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_hit(dec_hit), .busy(busy)
    );

    function automatic logic [NF-1:0] exp_hit(logic [W-1:0] id);
        logic [NF-1:0] h;
        for (int i = 0; i < NF; i++)
            h[i] = m_en[i] && (((id ^ m_fid[i]) & m_mask[i]) == '0);
        return h;
    endfunction

    function automatic logic exp_acc(logic [W-1:0] id);
        return (m_en == '0) ? 1'b1 : (|exp_hit(id));
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // write issued at a negedge when busy is known low; model follows R7/R8
    task automatic wr(logic [1:0] sel, int idx, logic [W-1:0] data);
        logic chg;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_idx = idx[1:0]; cfg_wdata = data;
        chg = 1'b0;
        case (sel)
            2'd0: if (!m_en[idx]) m_mask[idx] = data;
            2'd1: if (!m_en[idx]) m_fid[idx] = data;
            2'd2: begin chg = (data[NF-1:0] != m_en); m_en = data[NF-1:0]; end
            default: ;
        endcase
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_sel = 2'd3;
        if (sel == 2'd2) check("R7 busy after enable write", W'(busy), W'(chg));
    endtask

    task automatic send(logic [W-1:0] id, string req);
        @(negedge clk);
        id_valid = 1'b1; id_word = id;
        @(negedge clk);
        id_valid = 1'b0;
        check({req, " R5 valid"}, W'(dec_valid), W'(1));
        check({req, " R2 hit"}, W'(dec_hit), W'(exp_hit(id)));
        check({req, " R3/R4 accept"}, W'(dec_accept), W'(exp_acc(id)));
        check({req, " R6 busy"}, W'(busy), W'(1));
        @(negedge clk);
        check({req, " R5 valid drop"}, W'(dec_valid), W'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int seed;
        logic [W-1:0] id;
        seed = 17;
        void'($urandom(seed));
        for (int i = 0; i < NF; i++) begin m_mask[i] = '0; m_fid[i] = '0; end
        m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dec_valid", W'(dec_valid), 0);
        check("R1 dec_accept", W'(dec_accept), 0);
        check("R1 dec_hit", W'(dec_hit), 0);
        check("R1 busy", W'(busy), 0);
        send(32'h1234_5678, "R1/R4 all disabled");

        // R10: standard-id-only filter on filter 0
        wr(2'd0, 0, 32'hFFE0_0000);
        wr(2'd1, 0, {11'h123, 21'h0});
        wr(2'd2, 0, 32'h1);
        send({11'h123, 1'b1, 1'b1, 18'h2ABCD, 1'b1}, "R10 std match ext dont-care");
        send({11'h124, 21'h0}, "R10 std mismatch");

        // R8: match write to enabled filter ignored
        wr(2'd1, 0, {11'h7FF, 21'h0});
        send({11'h123, 21'h0}, "R8 old match kept");
        send({11'h7FF, 21'h0}, "R8 new match not loaded");
        wr(2'd3, 1, 32'hFFFF_FFFF);
        send(32'hFFFF_FFFF, "R8 sel3 writes nothing");

        // R7: same enable value -> no busy
        wr(2'd2, 0, 32'h1);

        // R9: enable write in busy cycle after enable change is dropped
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0;
        m_en = '0;
        @(negedge clk);
        check("R7 busy after disable", W'(busy), 1);
        cfg_wdata = 32'hF;             // still write-enabled while busy: must drop
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_sel = 2'd3;
        send(32'h0, "R9 enable write while busy dropped");

        // R9: mask write in busy cycle after id strobe dropped
        @(negedge clk);
        id_valid = 1'b1; id_word = 32'h0;
        @(negedge clk);
        id_valid = 1'b0;
        cfg_wr_en = 1'b1; cfg_sel = 2'd0; cfg_idx = 2'd1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_sel = 2'd3;
        wr(2'd1, 1, 32'hAAAA_0000);
        wr(2'd2, 0, 32'h2);
        send(32'h5555_0000, "R9 mask write while busy dropped");

        // random phase
        for (int n = 0; n < 400; n++) begin
            int op;
            int f;
            op = $urandom_range(0, 9);
            f = $urandom_range(0, NF - 1);
            if (op == 0) wr(2'd0, f, $urandom());
            else if (op == 1) wr(2'd1, f, $urandom());
            else if (op == 2) wr(2'd2, 0, W'($urandom_range(0, 15)));
            else begin
                id = $urandom();
                if (op > 5) id = m_fid[f] ^ ($urandom() & ~m_mask[f]);
                send(id, "R2/R3 random");
            end
        end
        done = 1;
        summary();
    end
endmodule